// File: doc/BRIEF.md
# Byte-Packed Element-Width Register File Port

This block holds an integer register file of 128 registers of 64 bits and treats it as one contiguous, little-endian byte memory of 1024 bytes. A requester names a base register, an element index and an element width, and the block reads or writes that one element. Narrow elements pack tightly, so a run of 8-bit elements starting at one register fills that register and then continues into the registers that follow it. A scalar request, with no vector length active, ignores the index and the width and moves the whole 64-bit register.

There is one read port and one write port. Both can be used in the same cycle. The read result is registered and zero-extended to 64 bits. The write takes the element from the low bits of its data and, through internal byte enables, changes only that element's bytes. A request whose element would reach past the end of the byte memory raises an error flag and does not touch the storage.

Top module: `ewrf_port`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0, `rd_err` and `wr_err` are 0, and every register reads as 0.
- R2: With the vector flag low, a request addresses the whole 64-bit register `base`, and the index and width inputs have no effect.
- R3: The width code is 01 for 8 bits, 10 for 16 bits, 11 for 32 bits and 00 for the native 64 bits. With the vector flag high, element i starts at byte offset base*8 + i*(width/8), and byte k of register r is byte offset r*8+k, where byte 0 is bits 7:0.
- R4: A read returns the element in the low bits of `rd_data` with all higher bits zero.
- R5: A write takes the element from the low bits of `wr_data` and changes only the width/8 bytes of that element. All other bytes keep their values.
- R6: Elements whose index carries them past the base register land in the following registers. For example, with base 5, width 8 and index 9, the element is byte 1 of register 6.
- R7: If the element's last byte offset is 1024 or more, the write changes no byte and a read returns `rd_data` = 0 with `rd_err` = 1.
- R8: A read and a write to the same bytes in the same cycle return the old contents. A read in the next cycle returns the new contents.
- R9: `rd_data` and `rd_err` update one clock edge after a cycle with `rd_en` high, and they hold their values while `rd_en` is low.
- R10: `wr_err` is 1 for exactly the cycle after a cycle in which `wr_en` was high with an out-of-range element, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_vec | input | 1 | Read uses the element addressing (1) or the whole register (0) |
| rd_ew | input | 2 | Read width code |
| rd_base | input | 7 | Read base register |
| rd_idx | input | 7 | Read element index |
| rd_data | output | 64 | Zero-extended read element |
| rd_err | output | 1 | Last read was out of range |
| wr_en | input | 1 | Write request |
| wr_vec | input | 1 | Write uses the element addressing (1) or the whole register (0) |
| wr_ew | input | 2 | Write width code |
| wr_base | input | 7 | Write base register |
| wr_idx | input | 7 | Write element index |
| wr_data | input | 64 | Write element, taken from the low bits |
| wr_err | output | 1 | Previous write was out of range |

## Verification
The bench tries the addressing with each of the four width codes on one known register. This separates lane selection from width masking. Narrow writes into the middle of a filled register show whether neighbouring bytes survive. Indices that run past the base register show whether the overrun reaches the correct following register rather than wrapping inside the base. Offsets just below and at the 1024-byte limit, for each width, separate the last legal element from the first illegal one. Long mixed random traffic, including same-cycle read and write to the same bytes, is compared every clock against a byte-array model, and that traffic exposes ordering and hold errors.

// File: rtl/ewrf_pkg.sv
// Shared types for the byte-packed register file port.
// Assumes a width code of two bits, with 00 meaning the native 64-bit width.
package ewrf_pkg;
    typedef enum logic [1:0] {
        EW_NATIVE = 2'b00,
        EW_B8     = 2'b01,
        EW_B16    = 2'b10,
        EW_B32    = 2'b11
    } ew_e;

    // Element size in bytes; a scalar request always moves 8 bytes.
    function automatic logic [3:0] ew_bytes(input logic vec, input ew_e ew);
        if (!vec) return 4'd8;
        case (ew)
            EW_B8:   return 4'd1;
            EW_B16:  return 4'd2;
            EW_B32:  return 4'd4;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/ewrf_addr.sv
// Address generator: maps (base, index, width) to a register row, a byte lane
// and a byte-enable mask, and flags elements that run past the byte array.
// Assumes NREGS is a power of two and elements are naturally aligned, so no
// element ever straddles two rows.
module ewrf_addr
    import ewrf_pkg::*;
#(
    parameter int NREGS = 128,
    parameter int IDX_W = 7,
    localparam int ROW_W = $clog2(NREGS)
) (
    input  logic             vec,
    input  ew_e              ew,
    input  logic [ROW_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    output logic [ROW_W-1:0] row,
    output logic [2:0]       lane,
    output logic [7:0]       be,
    output logic [3:0]       nbytes,
    output logic             oor
);
    localparam int BYTES = NREGS * 8;
    localparam int OFF_W = ((ROW_W > IDX_W) ? ROW_W : IDX_W) + 5;

    logic [OFF_W-1:0] off;
    logic [7:0]       base_mask;

    // Compute the byte offset, the range check and the shifted byte enables.
    always_comb begin
        nbytes = ew_bytes(vec, ew);
        if (vec)
            off = (OFF_W'(base) << 3) + OFF_W'(idx) * OFF_W'(nbytes);
        else
            off = OFF_W'(base) << 3;
        oor  = (off + OFF_W'(nbytes)) > OFF_W'(BYTES);
        row  = off[ROW_W+2:3];
        lane = off[2:0];
        case (nbytes)
            4'd1:    base_mask = 8'h01;
            4'd2:    base_mask = 8'h03;
            4'd4:    base_mask = 8'h0F;
            default: base_mask = 8'hFF;
        endcase
        be = oor ? 8'h00 : (base_mask << lane);
    end

    // R5: an in-range element enables exactly its own number of bytes.
    always_comb begin
        if (!oor)
            be_count_chk: assert ($countones(be) == int'(nbytes));
    end
endmodule

// File: rtl/ewrf_bank.sv
// Storage bank: eight byte-lane arrays of NREGS entries. Each lane has its own
// write enable and a registered read of the addressed row.
// Assumes one write row and one read row per cycle. A read returns the
// contents from before any same-cycle write.
module ewrf_bank #(
    parameter int NREGS = 128,
    localparam int ROW_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [7:0]       wr_be,
    input  logic [63:0]      wr_word,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    output logic [63:0]      rd_word
);
    for (genvar b = 0; b < 8; b++) begin : g_lane
        logic [7:0] cells [NREGS];
        logic [7:0] q;

        // Clear the lane, write the enabled byte, capture the read byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < NREGS; r++) cells[r] <= 8'h00;
                q <= 8'h00;
            end else begin
                if (wr_be[b]) cells[wr_row] <= wr_word[8*b +: 8];
                if (rd_en)    q <= cells[rd_row];
            end
        end

        assign rd_word[8*b +: 8] = q;
    end
endmodule

// File: rtl/ewrf_port.sv
// Top: one read port and one write port onto a byte-packed register file.
// Each port computes its own addressing. The read element is aligned and
// zero-extended after the registered bank read. Out-of-range writes are
// dropped and flagged one cycle later.
module ewrf_port
    import ewrf_pkg::*;
#(
    parameter int NREGS = 128,
    parameter int IDX_W = 7,
    localparam int ROW_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_vec,
    input  logic [1:0]       rd_ew,
    input  logic [ROW_W-1:0] rd_base,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data,
    output logic             rd_err,
    input  logic             wr_en,
    input  logic             wr_vec,
    input  logic [1:0]       wr_ew,
    input  logic [ROW_W-1:0] wr_base,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    output logic             wr_err
);
    logic [ROW_W-1:0] r_row, w_row;
    logic [2:0]       r_lane, w_lane;
    logic [7:0]       r_be, w_be;
    logic [3:0]       r_nb, w_nb;
    logic             r_oor, w_oor;
    logic [63:0]      bank_q;
    logic [2:0]       lane_q;
    logic [3:0]       nb_q;
    logic             err_q, werr_q;
    logic [63:0]      width_mask;

    ewrf_addr #(.NREGS(NREGS), .IDX_W(IDX_W)) u_raddr (
        .vec(rd_vec), .ew(ew_e'(rd_ew)), .base(rd_base), .idx(rd_idx),
        .row(r_row), .lane(r_lane), .be(r_be), .nbytes(r_nb), .oor(r_oor)
    );

    ewrf_addr #(.NREGS(NREGS), .IDX_W(IDX_W)) u_waddr (
        .vec(wr_vec), .ew(ew_e'(wr_ew)), .base(wr_base), .idx(wr_idx),
        .row(w_row), .lane(w_lane), .be(w_be), .nbytes(w_nb), .oor(w_oor)
    );

    ewrf_bank #(.NREGS(NREGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_row(w_row), .wr_be(wr_en ? w_be : 8'h00),
        .wr_word(wr_data << (8 * w_lane)),
        .rd_en(rd_en), .rd_row(r_row), .rd_word(bank_q)
    );

    // Keep the read alignment and range result alongside the bank read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= 3'd0;
            nb_q   <= 4'd0;
            err_q  <= 1'b0;
        end else if (rd_en) begin
            lane_q <= r_lane;
            nb_q   <= r_nb;
            err_q  <= r_oor;
        end
    end

    // Flag a dropped write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) werr_q <= 1'b0;
        else        werr_q <= wr_en & w_oor;
    end

    // Shift the addressed lane down and clear the bits above the element.
    always_comb begin
        width_mask = (nb_q >= 4'd8) ? {64{1'b1}} : ((64'd1 << (8 * nb_q)) - 64'd1);
        rd_data    = err_q ? 64'd0 : ((bank_q >> (8 * lane_q)) & width_mask);
        rd_err     = err_q;
        wr_err     = werr_q;
    end

    // R4
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_vec && rd_ew == 2'b01) |=> (rd_data[63:8] == 56'd0));
    // R7
    err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 64'd0));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(rd_err)));
    // R10
    werr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));
endmodule

// File: tb/sim_ewrf_port.sv
`timescale 1ns/1ps
// Bench: drives both ports and compares every cycle against a byte-array model.
module sim_ewrf_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 0, rd_vec = 0, wr_en = 0, wr_vec = 0;
    logic [1:0]  rd_ew = 0, wr_ew = 0;
    logic [6:0]  rd_base = 0, rd_idx = 0, wr_base = 0, wr_idx = 0;
    logic [63:0] wr_data = 0;
    logic [63:0] rd_data;
    logic        rd_err, wr_err;

    int          n_chk = 0, n_err = 0;
    logic [7:0]  mem [1024];
    logic [63:0] e_data = 0;
    logic        e_rerr = 0, e_werr = 0;

    always #10 clk = ~clk;

    ewrf_port u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_vec(rd_vec), .rd_ew(rd_ew), .rd_base(rd_base),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err),
        .wr_en(wr_en), .wr_vec(wr_vec), .wr_ew(wr_ew), .wr_base(wr_base),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err)
    );

    function automatic int nb(logic vec, logic [1:0] ew);
        if (!vec) return 8;
        return (ew == 2'b01) ? 1 : (ew == 2'b10) ? 2 : (ew == 2'b11) ? 4 : 8;
    endfunction

    function automatic int offs(logic vec, logic [1:0] ew, logic [6:0] b, logic [6:0] i);
        return vec ? (int'(b) * 8 + int'(i) * nb(vec, ew)) : int'(b) * 8;
    endfunction

    task automatic compare(string tag);
        n_chk++;
        if (rd_data !== e_data || rd_err !== e_rerr || wr_err !== e_werr) begin
            n_err++;
            $display("FAIL %s: got data=%h rerr=%b werr=%b, expected data=%h rerr=%b werr=%b",
                     tag, rd_data, rd_err, wr_err, e_data, e_rerr, e_werr);
        end
    endtask

    // One clock: model the edge (read before write), then compare at negedge.
    task automatic cyc(string tag);
        @(posedge clk);
        if (rd_en) begin
            int n = nb(rd_vec, rd_ew);
            int o = offs(rd_vec, rd_ew, rd_base, rd_idx);
            if (o + n > 1024) begin e_data = 0; e_rerr = 1; end
            else begin
                e_data = 0; e_rerr = 0;
                for (int k = 0; k < n; k++) e_data[8*k +: 8] = mem[o + k];
            end
        end
        e_werr = 0;
        if (wr_en) begin
            int n = nb(wr_vec, wr_ew);
            int o = offs(wr_vec, wr_ew, wr_base, wr_idx);
            if (o + n > 1024) e_werr = 1;
            else for (int k = 0; k < n; k++) mem[o + k] = wr_data[8*k +: 8];
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd(logic v, logic [1:0] ew, logic [6:0] b, logic [6:0] i, string tag);
        rd_en = 1; rd_vec = v; rd_ew = ew; rd_base = b; rd_idx = i;
        cyc(tag);
        rd_en = 0;
    endtask

    task automatic wr(logic v, logic [1:0] ew, logic [6:0] b, logic [6:0] i,
                      logic [63:0] d, string tag);
        wr_en = 1; wr_vec = v; wr_ew = ew; wr_base = b; wr_idx = i; wr_data = d;
        cyc(tag);
        wr_en = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1 reset outputs");
        rd(0, 2'b00, 7'd0, 7'd0, "R1 reg0 cleared");
        rd(0, 2'b00, 7'd127, 7'd0, "R1 reg127 cleared");

        // R2: scalar write and read ignore index and width
        wr(0, 2'b01, 7'd3, 7'd5, 64'h1122334455667788, "R2 scalar write");
        rd(0, 2'b01, 7'd3, 7'd6, "R2 scalar read");
        // R3 R4: each width code against the known register
        rd(1, 2'b01, 7'd3, 7'd0, "R3 byte idx0");
        rd(1, 2'b01, 7'd3, 7'd7, "R3 byte idx7");
        rd(1, 2'b10, 7'd3, 7'd1, "R4 half idx1");
        rd(1, 2'b11, 7'd3, 7'd1, "R4 word idx1");
        rd(1, 2'b00, 7'd3, 7'd0, "R3 native idx0");
        // R5: narrow write into a filled register
        wr(1, 2'b01, 7'd3, 7'd2, 64'hFFFF_FFFF_FFFF_FFAB, "R5 byte write");
        rd(0, 2'b00, 7'd3, 7'd0, "R5 neighbours kept");
        wr(1, 2'b10, 7'd3, 7'd3, 64'hDEAD_0000_0000_C0DE, "R5 half write");
        rd(0, 2'b00, 7'd3, 7'd0, "R5 half neighbours");
        // R6: overrun into following registers
        wr(1, 2'b10, 7'd10, 7'd5, 64'h0000_0000_0000_BEEF, "R6 half overrun write");
        rd(0, 2'b00, 7'd11, 7'd0, "R6 lands in reg11");
        wr(1, 2'b01, 7'd5, 7'd9, 64'h5A, "R6 byte overrun write");
        rd(0, 2'b00, 7'd6, 7'd0, "R6 lands in reg6 byte1");
        wr(1, 2'b00, 7'd100, 7'd27, 64'hCAFE_F00D_1234_5678, "R6 native last row");
        rd(0, 2'b00, 7'd127, 7'd0, "R6 native read back");
        // R7 R10: range boundaries
        wr(1, 2'b01, 7'd127, 7'd7, 64'h77, "R7 last legal byte");
        rd(1, 2'b01, 7'd127, 7'd7, "R7 last legal byte read");
        wr(1, 2'b11, 7'd127, 7'd2, 64'h99999999, "R10 word past end");
        rd(1, 2'b01, 7'd127, 7'd8, "R7 byte past end");
        wr(1, 2'b00, 7'd100, 7'd28, 64'h1, "R10 native past end");
        rd(0, 2'b00, 7'd0, 7'd0, "R7 no wrap into reg0");
        rd(1, 2'b10, 7'd127, 7'd4, "R7 half past end");
        // R8: same-cycle read and write
        rd_en = 1; rd_vec = 0; rd_base = 7'd20;
        wr_en = 1; wr_vec = 0; wr_base = 7'd20; wr_data = 64'h0102030405060708;
        cyc("R8 same cycle old");
        wr_en = 0;
        cyc("R8 next cycle new");
        rd_en = 0;
        // R9: hold with rd_en low while writes continue
        wr(0, 2'b00, 7'd20, 7'd0, 64'hFFFF, "R9 hold during write");
        cyc("R9 hold idle");

        // Mixed random traffic biased toward the top of the array
        for (int t = 0; t < 3000; t++) begin
            rd_en   = 1'($urandom);
            rd_vec  = 1'($urandom);
            rd_ew   = 2'($urandom);
            rd_base = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(110, 127)) : 7'($urandom_range(0, 40));
            rd_idx  = 7'($urandom);
            wr_en   = 1'($urandom);
            wr_vec  = 1'($urandom);
            wr_ew   = 2'($urandom);
            wr_base = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(110, 127)) : 7'($urandom_range(0, 40));
            wr_idx  = 7'($urandom);
            wr_data = {$urandom, $urandom};
            if (t % 5 == 0) begin rd_base = wr_base; rd_idx = wr_idx; rd_ew = wr_ew; end
            cyc("R3 random");
        end
        rd_en = 0; wr_en = 0;
        cyc("R9 final");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule